// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Code Register

This block is the digital front end of a 12-bit parallel-input digital-to-analog converter, modelled synchronously to one system clock. A 12-bit data bus feeds two input holding registers: an 8-bit low part and a 4-bit high part. Each part has its own active-low select. Both parts share one active-low write strobe. A second 12-bit code register, loaded from the holding registers under an active-low load strobe, drives the code sent to the analog converter. Software can therefore build a new word in one or two bus writes. It then commits that word to the output in a single step.

All strobes are sampled on the rising clock edge. A holding register whose write strobe and select are both low copies the bus on every edge. When either of them rises, the register keeps the value it took at the last edge it was open. The code register works the same way under the load strobe. It takes the value the holding registers receive at that same edge, so with every strobe low the bus reaches the output code one clock later. A power-on reset input and a clear input are both asynchronous and active low. Each one forces every register to zero and overrides all strobes.

The write decoder sorts each edge into one of four modes:
- `WM_NONE`: nothing is written.
- `WM_LO`: only the low part is written.
- `WM_HI`: only the high part is written.
- `WM_BOTH`: both parts are written.

The code register has a two-state machine, `OR_HOLD` and `OR_TRACK`. It moves from `OR_HOLD` to `OR_TRACK` on an edge where the load strobe is low, and from `OR_TRACK` to `OR_HOLD` on an edge where the load strobe is high. Reset or clear sends it to `OR_HOLD`. A one-cycle update pulse marks every load that changes the output code.

Top module: `dac_dbuf_reg`

## Requirements
- R1: A holding register changes only at an edge where the write strobe and its own select are both low. A write with neither select low, or a select with the write strobe high, changes no stored bit.
- R2: With write low, low select low and high select high, holding bits 7:0 take data bits 7:0 and holding bits 11:8 keep their value.
- R3: With write low, high select low and low select high, holding bits 11:8 take data bits 11:8 and holding bits 7:0 keep their value.
- R4: With write and both selects low, all 12 holding bits take the data bus at the same edge.
- R5: After a strobe rises, the holding register keeps the value sampled at the last edge at which it was open.
- R6: At an edge with the load strobe low, the output code takes the holding-register value, including any write made at that same edge. At an edge with the load strobe high, the output code keeps its value.
- R7: At an edge with write, both selects and load all low, the output code becomes the data bus value sampled at that edge.
- R8: While power-on reset is low, the output code, the update pulse and both holding registers are zero, from the moment reset falls.
- R9: While clear is low, the output code, the update pulse and both holding registers are zero, from the moment clear falls, and no strobe changes any register.
- R10: The update pulse is high for exactly the one cycle after an edge at which a load changed the output code, and low at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| clr_n | input | 1 | Asynchronous clear, active low, overrides all strobes |
| wr_n | input | 1 | Write strobe, active low, shared by both holding parts |
| sel_lo_n | input | 1 | Low-part select (bits 7:0), active low |
| sel_hi_n | input | 1 | High-part select (bits 11:8), active low |
| ld_n | input | 1 | Load strobe for the code register, active low |
| din | input | 12 | Parallel data bus |
| code | output | 12 | Output code for the analog converter |
| code_upd | output | 1 | One-cycle pulse after a load that changed the code |

## Verification
The functions that can fall in the same cycle are a holding-register write and a code load. When both act at the same edge, the output must show the freshly written bits rather than the stale ones. Directed steps drive write, one or both selects, and load low together with a data pattern that differs from the held word. The random phase mixes all strobes independently so that partial writes often coincide with loads. The bench compares the code and the update pulse against a reference model that applies the write before the load within each edge. Clear asserted together with active strobes is judged the same way and must leave everything at zero.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

    localparam int unsigned LO_W   = 8;
    localparam int unsigned HI_W   = 4;
    localparam int unsigned CODE_W = LO_W + HI_W;

    typedef enum logic [1:0] {
        WM_NONE = 2'd0,
        WM_LO   = 2'd1,
        WM_HI   = 2'd2,
        WM_BOTH = 2'd3
    } wr_mode_e;

    typedef enum logic {
        OR_HOLD  = 1'b0,
        OR_TRACK = 1'b1
    } out_state_e;

endpackage

// File: rtl/dac_strobe_dec.sv
module dac_strobe_dec
    import dac_dbuf_pkg::*;
(
    input  logic clr_n,
    input  logic wr_n,
    input  logic sel_lo_n,
    input  logic sel_hi_n,
    input  logic ld_n,
    output logic open_lo,
    output logic open_hi,
    output logic load_en
);

    wr_mode_e mode;

    // classify the write at this edge; clear overrides everything
    always_comb begin
        mode = WM_NONE;
        if (clr_n && !wr_n) begin
            unique case ({sel_hi_n, sel_lo_n})
                2'b00:   mode = WM_BOTH;
                2'b10:   mode = WM_LO;
                2'b01:   mode = WM_HI;
                default: mode = WM_NONE;
            endcase
        end
    end

    always_comb begin
        open_lo = 1'b0;
        open_hi = 1'b0;
        unique case (mode)
            WM_BOTH: begin open_lo = 1'b1; open_hi = 1'b1; end
            WM_LO:   open_lo = 1'b1;
            WM_HI:   open_hi = 1'b1;
            default: ;
        endcase
    end

    assign load_en = clr_n && !ld_n;

    always_comb begin
        if (clr_n && (wr_n || (sel_lo_n && sel_hi_n)))
            assert (!open_lo && !open_hi); // R1
    end

endmodule

// File: rtl/dac_hold_reg.sv
module dac_hold_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         open_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_next
);

    assign q_next = open_en ? d : q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= '0;
        else         q <= q_next;
    end

    AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (!arst_n)
        !open_en |=> $stable(q)); // R5

    AST_OPEN_TRACK: assert property (@(posedge clk) disable iff (!arst_n)
        open_en |=> (q == $past(d))); // R4

endmodule

// File: rtl/dac_code_reg.sv
module dac_code_reg
    import dac_dbuf_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         load_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] code,
    output logic         code_upd
);

    out_state_e   st_q, st_d;
    logic [W-1:0] code_d;
    logic         upd_d;

    // state register
    always_comb st_d = load_en ? OR_TRACK : OR_HOLD;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= OR_HOLD;
        else         st_q <= st_d;
    end

    // outputs
    always_comb begin
        code_d = code;
        upd_d  = 1'b0;
        unique case (st_d)
            OR_TRACK: begin
                code_d = d;
                upd_d  = (d != code);
            end
            OR_HOLD: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            code     <= '0;
            code_upd <= 1'b0;
        end else begin
            code     <= code_d;
            code_upd <= upd_d;
        end
    end

    AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
        !load_en |=> $stable(code)); // R6

    AST_UPD_CHANGE: assert property (@(posedge clk) disable iff (!arst_n)
        code_upd |-> (code != $past(code))); // R10

    AST_UPD_AFTER_LOAD: assert property (@(posedge clk) disable iff (!arst_n)
        code_upd |-> (st_q == OR_TRACK)); // R10

endmodule

// File: rtl/dac_dbuf_reg.sv
module dac_dbuf_reg
    import dac_dbuf_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              clr_n,
    input  logic              wr_n,
    input  logic              sel_lo_n,
    input  logic              sel_hi_n,
    input  logic              ld_n,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] code,
    output logic              code_upd
);

    logic              arst_n;
    logic              open_lo, open_hi, load_en;
    logic [LO_W-1:0]   lo_q, lo_next;
    logic [HI_W-1:0]   hi_q, hi_next;

    assign arst_n = por_n & clr_n;

    dac_strobe_dec i_dec (
        .clr_n    (clr_n),
        .wr_n     (wr_n),
        .sel_lo_n (sel_lo_n),
        .sel_hi_n (sel_hi_n),
        .ld_n     (ld_n),
        .open_lo  (open_lo),
        .open_hi  (open_hi),
        .load_en  (load_en)
    );

    dac_hold_reg #(.W(LO_W)) i_hold_lo (
        .clk     (clk),
        .arst_n  (arst_n),
        .open_en (open_lo),
        .d       (din[LO_W-1:0]),
        .q       (lo_q),
        .q_next  (lo_next)
    );

    dac_hold_reg #(.W(HI_W)) i_hold_hi (
        .clk     (clk),
        .arst_n  (arst_n),
        .open_en (open_hi),
        .d       (din[CODE_W-1:LO_W]),
        .q       (hi_q),
        .q_next  (hi_next)
    );

    dac_code_reg #(.W(CODE_W)) i_code (
        .clk      (clk),
        .arst_n   (arst_n),
        .load_en  (load_en),
        .d        ({hi_next, lo_next}),
        .code     (code),
        .code_upd (code_upd)
    );

    AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!por_n || !clr_n)
        (!wr_n && !sel_lo_n && !sel_hi_n && !ld_n) |=> (code == $past(din))); // R7

    AST_LO_ONLY: assert property (@(posedge clk) disable iff (!por_n || !clr_n)
        (!wr_n && !sel_lo_n && sel_hi_n) |=> (hi_q == $past(hi_q))); // R2

    AST_HI_ONLY: assert property (@(posedge clk) disable iff (!por_n || !clr_n)
        (!wr_n && sel_lo_n && !sel_hi_n) |=> (lo_q == $past(lo_q))); // R3

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        !clr_n |-> (code == '0 && !code_upd && lo_q == '0 && hi_q == '0)); // R9

    AST_POR_ZERO: assert property (@(posedge clk)
        !por_n |-> (code == '0 && !code_upd)); // R8

endmodule

// File: tb/test_dac_dbuf_reg.sv
module test_dac_dbuf_reg;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, clr_n = 1'b1;
    logic        wr_n = 1'b1, sel_lo_n = 1'b1, sel_hi_n = 1'b1, ld_n = 1'b1;
    logic [11:0] din = '0;
    logic [11:0] code;
    logic        code_upd;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference model state
    logic [7:0]  m_lo = '0;
    logic [3:0]  m_hi = '0;
    logic [11:0] m_code = '0;
    logic        m_upd = 1'b0;

    always #10 clk = ~clk;

    dac_dbuf_reg i_dac_dbuf_reg (
        .clk(clk), .por_n(por_n), .clr_n(clr_n), .wr_n(wr_n),
        .sel_lo_n(sel_lo_n), .sel_hi_n(sel_hi_n), .ld_n(ld_n),
        .din(din), .code(code), .code_upd(code_upd)
    );

    task automatic check(input string req, input logic [11:0] exp_code, input logic exp_upd);
        total++;
        if (code !== exp_code || code_upd !== exp_upd) begin
            bad++;
            $display("FAIL %s: code=%h upd=%b expected code=%h upd=%b",
                     req, code, code_upd, exp_code, exp_upd);
        end
    endtask

    function automatic logic [11:0] next_code(input logic w, input logic sl, input logic sh,
                                              input logic l, input logic [11:0] d);
        logic [7:0] lo; logic [3:0] hi;
        lo = (!w && !sl) ? d[7:0]  : m_lo;
        hi = (!w && !sh) ? d[11:8] : m_hi;
        return !l ? {hi, lo} : m_code;
    endfunction

    // drive at negedge, advance model to the next edge, check at the next negedge
    task automatic step(input logic w, input logic sl, input logic sh, input logic l,
                        input logic [11:0] d, input logic c, input string req);
        logic [11:0] nc;
        wr_n = w; sel_lo_n = sl; sel_hi_n = sh; ld_n = l; din = d; clr_n = c;
        if (!c || !por_n) begin
            m_lo = '0; m_hi = '0; m_code = '0; m_upd = 1'b0;
        end else begin
            nc = next_code(w, sl, sh, l, d);
            m_upd = (!l) && (nc != m_code);
            m_code = nc;
            if (!w && !sl) m_lo = d[7:0];
            if (!w && !sh) m_hi = d[11:8];
        end
        @(negedge clk);
        check(req, m_code, m_upd);
    endtask

    initial begin
        @(negedge clk);
        check("R8 reset state", 12'h000, 1'b0);
        por_n = 1'b1;
        @(negedge clk);
        // R4 full write then load
        step(0, 0, 0, 1, 12'hA5C, 1, "R4 full write, no load");
        step(1, 1, 1, 0, 12'hFFF, 1, "R4 load after full write");
        step(1, 1, 1, 1, 12'h000, 1, "R10 pulse ends");
        // R2 low only
        step(0, 0, 1, 0, 12'h3E1, 1, "R2 low part write with load");
        // R3 high only
        step(0, 1, 0, 0, 12'h7BB, 1, "R3 high part write with load");
        // R1 write without select ignored
        step(0, 1, 1, 1, 12'h123, 1, "R1 write without select");
        step(1, 1, 1, 0, 12'h456, 1, "R1 load shows no change");
        // R1 select without write ignored
        step(1, 0, 0, 1, 12'h999, 1, "R1 select without write");
        step(1, 1, 1, 0, 12'h999, 1, "R1 load shows no change");
        // R5 capture on select rise: open two cycles then close
        step(0, 0, 0, 1, 12'h111, 1, "R5 open 1");
        step(0, 0, 0, 1, 12'h222, 1, "R5 open 2");
        step(0, 1, 1, 1, 12'h333, 1, "R5 selects rise");
        step(1, 1, 1, 0, 12'h444, 1, "R5 load shows last open value");
        // R6 hold while load high
        step(0, 0, 0, 1, 12'hC3C, 1, "R6 hold with load high");
        // R7 transparent
        step(0, 0, 0, 0, 12'h5A5, 1, "R7 transparent 1");
        step(0, 0, 0, 0, 12'hE01, 1, "R7 transparent 2");
        step(0, 0, 0, 0, 12'hE01, 1, "R10 no pulse on same value");
        // R9 clear with active strobes, async effect
        clr_n = 1'b0; #1;
        check("R9 clear acts at once", 12'h000, 1'b0);
        step(0, 0, 0, 0, 12'hFFF, 0, "R9 strobes ignored in clear");
        step(1, 1, 1, 0, 12'h000, 1, "R9 latches zero after clear");
        // R8 async power-on reset
        step(0, 0, 0, 0, 12'h8F1, 1, "R7 before reset");
        por_n = 1'b0; #1;
        check("R8 reset acts at once", 12'h000, 1'b0);
        m_lo = '0; m_hi = '0; m_code = '0; m_upd = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        // random phase
        void'($urandom(32'd1450));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom();
            step(r[0] & r[1], r[2] & r[3], r[4] & r[5], r[6], 12'($urandom()),
                 (r[11:8] != 4'd0), "R6 R10 random");
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule